// File: doc/BRIEF.md
# Fault interrupt aggregation controller

This block gathers fault indications from a power-management die into one interrupt line. Each of six regulators has three fault inputs: under-voltage, over-voltage and over-current. There are also four system warnings: thermal warning, thermal shutdown, supply under-voltage and supply over-voltage. Every fault has three bits: a sticky event that a read clears, a live status, and a mask. A host reaches these bits through a byte-wide register port. The fault inputs arrive already synchronised to `clk`.

The interrupt pin is open-drain and active low, so it is modelled as an output enable. `irq_oe_o = 1` means the pad pulls low. The pin asserts while an unmasked event is pending, unless the host has since written the interrupt-release bit. A release does not clear the events. The pin asserts again when a new unmasked event is latched, or when a masked event that is still pending becomes unmasked.

Rail packing, used by every per-rail register: the main buck is bit 7, LDO1 to LDO4 are bits 6 to 3, and the second buck is bit 1. Input index 0 is the main buck, indices 1 to 4 are LDO1 to LDO4, and index 5 is the second buck. The system register uses bit 7 for thermal warning, bit 6 for thermal shutdown, bit 5 for supply under-voltage and bit 4 for supply over-voltage; these are `sys_flt_i[3:0]` in that order.

Top module: `fault_irq_ctrl`

## Requirements
- R1: On the clock edge that first samples a fault input at 1 (after it was 0), the matching event bit becomes 1. It stays 1 after the fault goes away, and a fault that remains high does not set it again once it has been cleared.
- R2: The status bits follow the sampled fault inputs with one clock of delay. Status registers are at 0x2B (under-voltage), 0x2C (over-voltage), 0x2D (over-current) and 0x2F (system).
- R3: A read of an event register returns its bits in `rdata_o` after the read edge, and clears that register at the same edge. Event registers are at 0x15 (under-voltage), 0x16 (over-voltage), 0x17 (over-current) and 0x19 (system).
- R4: If a fault rises in the same cycle as a read-clear of its register, the read returns the old value and the new event bit stays set.
- R5: `irq_oe_o` is 1 only while an unmasked event is pending and the interrupt is armed. An unmasked event that is newly latched arms the interrupt.
- R6: Writing 1 to bit 0 at address 0x14 drops `irq_oe_o` and leaves the event bits unchanged. Address 0x14 always reads 0.
- R7: After a release write, a newly latched unmasked event asserts `irq_oe_o` again.
- R8: Mask registers are at 0x1A, 0x1B, 0x1C and 0x1E, one for each event register in the same order. A 1 in a mask bit keeps its event from asserting the pin. Clearing a mask bit while its event is still pending asserts the pin.
- R9: While `hw_en_i` is 0, every mask register is held at its default value (`MASK_RST`, 0 by default), and mask writes are ignored.
- R10: Unimplemented bits read as 0: per-rail registers implement only 0xFA and the system registers only 0xF0. Writes to event, status or unmapped addresses have no effect, and unmapped addresses read 0.
- R11: After reset, `irq_oe_o` is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-down reset |
| hw_en_i | input | 1 | Hardware enable; while low, the masks return to default |
| uv_flt_i | input | 6 | Under-voltage fault for each rail |
| ov_flt_i | input | 6 | Over-voltage fault for each rail |
| oc_flt_i | input | 6 | Over-current fault for each rail |
| sys_flt_i | input | 4 | Thermal warning, thermal shutdown, supply UV, supply OV (bits 3 to 0) |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered at the read edge |
| irq_oe_o | output | 1 | 1 = interrupt pad pulls low |

## Verification
A change on a fault input appears in the status, event and `irq_oe_o` state one edge later. A read strobe places its data on `rdata_o` at the edge it is sampled. That same edge clears the event, and `irq_oe_o` responds right after it. Mask writes, release writes and `hw_en_i` also act at the single edge that samples them. The bench therefore changes inputs on the falling edge and reads results on the next falling edge, half a period after the edge that is responsible for them. The set-versus-clear collision is driven in one cycle, so that the read data and the surviving event bit can each be checked.

// File: rtl/fint_pkg.sv
package fint_pkg;
  localparam int DW       = 8;
  localparam int AW       = 8;
  localparam int NUM_RAIL = 6;
  localparam int NUM_SYS  = 4;
  localparam int NUM_GRP  = 4;
  localparam int VW       = NUM_GRP * DW;
  localparam int CLR_BIT  = 0;

  localparam logic [AW-1:0] ADDR_CTRL = 8'h14;
  localparam logic [AW-1:0] MASK_OFS  = 8'h05;
  localparam logic [AW-1:0] STAT_OFS  = 8'h16;

  // group 0: under-voltage, 1: over-voltage, 2: over-current, 3: system
  function automatic logic [AW-1:0] evt_addr(input int g);
    case (g)
      0:       return 8'h15;
      1:       return 8'h16;
      2:       return 8'h17;
      default: return 8'h19;
    endcase
  endfunction

  function automatic logic [AW-1:0] mask_addr(input int g);
    return evt_addr(g) + MASK_OFS;
  endfunction

  function automatic logic [AW-1:0] stat_addr(input int g);
    return evt_addr(g) + STAT_OFS;
  endfunction

  function automatic logic [DW-1:0] grp_impl(input int g);
    return (g < NUM_GRP - 1) ? 8'hFA : 8'hF0;
  endfunction

  function automatic logic [VW-1:0] impl_all_f();
    logic [VW-1:0] v;
    for (int g = 0; g < NUM_GRP; g++) v[g*DW +: DW] = grp_impl(g);
    return v;
  endfunction

  // rail index 0 = main buck, 1..4 = LDO1..LDO4, 5 = second buck
  function automatic logic [DW-1:0] rail_pack(input logic [NUM_RAIL-1:0] r);
    return {r[0], r[1], r[2], r[3], r[4], 1'b0, r[5], 1'b0};
  endfunction

  function automatic logic [DW-1:0] sys_pack(input logic [NUM_SYS-1:0] s);
    return {s, {(DW-NUM_SYS){1'b0}}};
  endfunction
endpackage

// File: rtl/fint_group.sv
module fint_group
  import fint_pkg::*;
#(
  parameter int            GIDX     = 0,
  parameter logic [DW-1:0] MASK_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_en_i,
  input  logic [DW-1:0] flt_i,
  input  logic          rd_clr_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] evt_o,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic          new_hit_o,
  output logic          uncover_o
);
  localparam logic [DW-1:0] IMPL = grp_impl(GIDX);

  logic [DW-1:0] stat_q, stat_d, evt_q, evt_d, mask_q, mask_d, rise;
  logic          stat_en, evt_en, mask_en;

  always_comb begin
    stat_d  = flt_i & IMPL;
    stat_en = (stat_d != stat_q);
    rise    = stat_d & ~stat_q;

    // a fresh edge wins over a read-clear in the same cycle
    evt_d = rd_clr_i ? '0 : evt_q;
    evt_d = evt_d | rise;
    evt_en = rd_clr_i | (|rise);

    mask_d  = mask_q;
    mask_en = 1'b0;
    if (!hw_en_i) begin
      mask_d  = MASK_RST & IMPL;
      mask_en = 1'b1;
    end else if (mask_we_i) begin
      mask_d  = wdata_i & IMPL;
      mask_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      evt_q  <= '0;
      mask_q <= MASK_RST & IMPL;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (evt_en)  evt_q  <= evt_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign new_hit_o = |(rise & ~mask_d);
  assign uncover_o = |(evt_q & mask_q & ~mask_d);
  assign evt_o     = evt_q;
  assign stat_o    = stat_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/fint_irq.sv
module fint_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_req_i,
  input  logic arm_req_i,
  input  logic pend_i,
  output logic irq_oe_o
);
  logic armed_q, armed_d, armed_en;

  always_comb begin
    armed_d  = armed_q;
    armed_en = 1'b0;
    if (arm_req_i) begin
      armed_d  = 1'b1;
      armed_en = 1'b1;
    end else if (clr_req_i) begin
      armed_d  = 1'b0;
      armed_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign irq_oe_o = armed_q & pend_i;
endmodule

// File: rtl/fint_rdmux.sv
module fint_rdmux
  import fint_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [VW-1:0]      evt_all_i,
  input  logic [VW-1:0]      stat_all_i,
  input  logic [VW-1:0]      mask_all_i,
  output logic [NUM_GRP-1:0] rd_clr_o,
  output logic [DW-1:0]      rdata_o
);
  logic [DW-1:0] rd_sel, rdata_q;

  always_comb begin
    rd_sel   = '0;
    rd_clr_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (addr_i == evt_addr(g)) begin
        rd_sel      = rd_sel | evt_all_i[g*DW +: DW];
        rd_clr_o[g] = rd_en_i;
      end
      if (addr_i == mask_addr(g)) rd_sel = rd_sel | mask_all_i[g*DW +: DW];
      if (addr_i == stat_addr(g)) rd_sel = rd_sel | stat_all_i[g*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_sel;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fint_pkg::*;
#(
  parameter logic [DW-1:0] MASK_RST = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_en_i,
  input  logic [NUM_RAIL-1:0] uv_flt_i,
  input  logic [NUM_RAIL-1:0] ov_flt_i,
  input  logic [NUM_RAIL-1:0] oc_flt_i,
  input  logic [NUM_SYS-1:0]  sys_flt_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                irq_oe_o
);
  logic [VW-1:0]      flt_all, evt_all, stat_all, mask_all;
  logic [NUM_GRP-1:0] rd_clr, mask_we, new_hit, uncover;
  logic               clr_req, arm_req, pend_any;

  always_comb begin
    flt_all = {sys_pack(sys_flt_i), rail_pack(oc_flt_i),
               rail_pack(ov_flt_i), rail_pack(uv_flt_i)};
    for (int g = 0; g < NUM_GRP; g++)
      mask_we[g] = wr_en_i && (addr_i == mask_addr(g));
    clr_req = wr_en_i && (addr_i == ADDR_CTRL) && wdata_i[CLR_BIT];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_grp
      fint_group #(.GIDX(g), .MASK_RST(MASK_RST)) u_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_en_i   (hw_en_i),
        .flt_i     (flt_all[g*DW +: DW]),
        .rd_clr_i  (rd_clr[g]),
        .mask_we_i (mask_we[g]),
        .wdata_i   (wdata_i),
        .evt_o     (evt_all[g*DW +: DW]),
        .stat_o    (stat_all[g*DW +: DW]),
        .mask_o    (mask_all[g*DW +: DW]),
        .new_hit_o (new_hit[g]),
        .uncover_o (uncover[g])
      );
    end
  endgenerate

  assign pend_any = |(evt_all & ~mask_all);
  assign arm_req  = |{new_hit, uncover};

  fint_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_req_i (clr_req),
    .arm_req_i (arm_req),
    .pend_i    (pend_any),
    .irq_oe_o  (irq_oe_o)
  );

  fint_rdmux u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .evt_all_i  (evt_all),
    .stat_all_i (stat_all),
    .mask_all_i (mask_all),
    .rd_clr_o   (rd_clr),
    .rdata_o    (rdata_o)
  );
endmodule

module fault_irq_ctrl_chk
  import fint_pkg::*;
#(
  parameter logic [DW-1:0] MASK_RST = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hw_en_i,
  input logic               rd_en_i,
  input logic [AW-1:0]      addr_i,
  input logic [DW-1:0]      rdata_o,
  input logic               irq_oe_o,
  input logic [VW-1:0]      flt_all,
  input logic [VW-1:0]      evt_all,
  input logic [VW-1:0]      stat_all,
  input logic [VW-1:0]      mask_all,
  input logic [NUM_GRP-1:0] rd_clr
);
  localparam logic [VW-1:0] IMPL_ALL = impl_all_f();
  localparam logic [VW-1:0] MASK_DEF = {NUM_GRP{MASK_RST}} & IMPL_ALL;

  logic          seen_q;
  logic [VW-1:0] clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  always_comb
    for (int g = 0; g < NUM_GRP; g++) clr_mask[g*DW +: DW] = {DW{rd_clr[g]}};

  // R2: status is the sampled fault vector one edge later
  p_status_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> stat_all == ($past(flt_all) & IMPL_ALL));

  // R1: a sampled rising edge always leaves its event bit set
  p_rise_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((($past(flt_all) & ~$past(stat_all) & IMPL_ALL) & ~evt_all) == '0));

  // R1: event bits drop only through a read-clear
  p_event_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((($past(evt_all) & ~$past(clr_mask)) & ~evt_all) == '0));

  // R6: release register reads zero
  p_ctrl_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(rd_en_i && addr_i == ADDR_CTRL)) |-> rdata_o == '0);

  // R9: low hardware enable returns masks to default
  p_mask_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(!hw_en_i)) |-> mask_all == MASK_DEF);

  // R8: fully masked controller never pulls the pin
  p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_all == IMPL_ALL) |-> !irq_oe_o);

  // R5: no pending event, no interrupt
  p_no_irq_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_all == '0) |-> !irq_oe_o);
endmodule

bind fault_irq_ctrl fault_irq_ctrl_chk #(.MASK_RST(MASK_RST)) u_chk (.*);

// File: tb/fault_irq_ctrl_test.sv
module fault_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hw_en;
  logic [5:0] uv, ov, oc;
  logic [3:0] sys;
  logic       rd_en, wr_en;
  logic [7:0] addr, wdata;
  logic [7:0] rdata;
  logic       irq;
  logic [7:0] d;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 0;

  always #2 clk = ~clk;

  fault_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hw_en_i(hw_en),
    .uv_flt_i(uv), .ov_flt_i(ov), .oc_flt_i(oc), .sys_flt_i(sys),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_oe_o(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // fault index: 0..5 UV rails, 6..11 OV, 12..17 OC, 18..21 system bits 3..0
  task automatic set_fault(input int i, input bit on);
    @(negedge clk);
    uv = '0; ov = '0; oc = '0; sys = '0;
    if (on) begin
      if (i < 6)       uv = 6'(1 << i);
      else if (i < 12) ov = 6'(1 << (i - 6));
      else if (i < 18) oc = 6'(1 << (i - 12));
      else             sys = 4'(8 >> (i - 18));
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_en = 1'b1;
    uv = '0; ov = '0; oc = '0; sys = '0;
    rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11", "irq after reset", {7'b0, irq}, 8'h00);
    for (int g = 0; g < 4; g++) begin
      logic [7:0] ea;
      ea = (g < 3) ? 8'(8'h15 + g) : 8'h19;
      rd(ea, d);           chk("R11", "event reset", d, 8'h00);
      rd(ea + 8'h05, d);   chk("R11", "mask reset", d, 8'h00);
      rd(ea + 8'h16, d);   chk("R11", "status reset", d, 8'h00);
    end

    // R1 R2 R3 R5: sweep every fault input
    for (int i = 0; i < 22; i++) begin
      int g, pos;
      logic [7:0] ea, sa, bitv;
      if (i < 18) begin
        g = i / 6;
        pos = (i % 6 == 5) ? 1 : 7 - (i % 6);
      end else begin
        g = 3;
        pos = 7 - (i - 18);
      end
      ea = (g < 3) ? 8'(8'h15 + g) : 8'h19;
      sa = ea + 8'h16;
      bitv = 8'(1 << pos);
      set_fault(i, 1'b1);
      chk("R5", "irq on new event", {7'b0, irq}, 8'h01);
      rd(sa, d);  chk("R2", "status while held", d, bitv);
      rd(ea, d);  chk("R3", "event read", d, bitv);
      chk("R5", "irq after read-clear", {7'b0, irq}, 8'h00);
      rd(ea, d);  chk("R1", "no re-set while held", d, 8'h00);
      set_fault(i, 1'b0);
      rd(sa, d);  chk("R2", "status after removal", d, 8'h00);
    end

    // R1: event survives fault removal
    set_fault(3, 1'b1);
    set_fault(3, 1'b0);
    chk("R1", "irq after pulse", {7'b0, irq}, 8'h01);
    rd(8'h15, d); chk("R1", "sticky event", d, 8'h10);

    // R6 R7: release write then new event
    set_fault(17, 1'b1);
    chk("R5", "irq oc rail5", {7'b0, irq}, 8'h01);
    wr(8'h14, 8'h01);
    chk("R6", "irq after release", {7'b0, irq}, 8'h00);
    rd(8'h14, d); chk("R6", "ctrl reads zero", d, 8'h00);
    set_fault(6, 1'b1);
    chk("R7", "irq re-asserted", {7'b0, irq}, 8'h01);
    rd(8'h16, d); chk("R7", "ov event", d, 8'h80);
    chk("R6", "irq with kept event", {7'b0, irq}, 8'h01);
    rd(8'h17, d); chk("R6", "event kept over release", d, 8'h02);
    chk("R5", "irq after all read", {7'b0, irq}, 8'h00);
    set_fault(0, 1'b0);

    // R8 R10: mask then uncover
    wr(8'h1A, 8'hFF);
    rd(8'h1A, d); chk("R10", "rail mask bits", d, 8'hFA);
    set_fault(0, 1'b1);
    chk("R8", "masked event quiet", {7'b0, irq}, 8'h00);
    rd(8'h2B, d); chk("R8", "status under mask", d, 8'h80);
    wr(8'h1A, 8'h00);
    chk("R8", "uncover asserts", {7'b0, irq}, 8'h01);
    rd(8'h15, d); chk("R8", "uncovered event", d, 8'h80);
    set_fault(0, 1'b0);
    wr(8'h1E, 8'hFF);
    rd(8'h1E, d); chk("R10", "system mask bits", d, 8'hF0);

    // R9: hardware enable returns masks to default
    wr(8'h1B, 8'hFF);
    set_fault(7, 1'b1);
    chk("R8", "ov masked quiet", {7'b0, irq}, 8'h00);
    @(negedge clk); hw_en = 1'b0;
    wr(8'h1C, 8'hFF);
    @(negedge clk); hw_en = 1'b1;
    @(negedge clk);
    chk("R9", "irq after mask default", {7'b0, irq}, 8'h01);
    rd(8'h1B, d); chk("R9", "ov mask default", d, 8'h00);
    rd(8'h1C, d); chk("R9", "write while disabled", d, 8'h00);
    rd(8'h1E, d); chk("R9", "sys mask default", d, 8'h00);
    rd(8'h16, d); chk("R9", "ov event", d, 8'h40);
    set_fault(7, 1'b0);

    // R4: rise collides with read-clear
    @(negedge clk); rd_en = 1'b1; addr = 8'h16; ov = 6'b001000;
    @(negedge clk); rd_en = 1'b0; d = rdata;
    chk("R4", "read returns old", d, 8'h00);
    rd(8'h16, d); chk("R4", "set survives clear", d, 8'h10);
    set_fault(9, 1'b0);

    // R10: ignored writes
    wr(8'h15, 8'hFF);
    wr(8'h2B, 8'hFF);
    wr(8'h40, 8'hFF);
    chk("R10", "irq after ignored writes", {7'b0, irq}, 8'h00);
    rd(8'h15, d); chk("R10", "event write ignored", d, 8'h00);
    rd(8'h2B, d); chk("R10", "status write ignored", d, 8'h00);
    rd(8'h40, d); chk("R10", "unmapped reads zero", d, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule